// File: doc/BRIEF.md
# Open-String Latch-Off Diagnostic Controller

This block is the digital fault supervisor of an eight-channel constant-current LED driver. Analog comparators in the driver produce one open-load flag per channel. They also produce a supply-above-threshold flag, an undervoltage-lockout flag and several bias-fault flags. The block turns these into two registered outputs: a global kill signal that forces every channel off, and a diagnostic status line that is high whenever something is wrong.

Each open-load flag is counted and accepted only after it has been seen for a programmable number of driven cycles. Counting is armed only once the supply has risen above the open-load threshold. Channels that are found strapped to ground when the block arms are masked for the rest of the run. A latch-off select input decides how an accepted open string is handled. It either latches every channel off or is only reported. A latched state is released by a forced-low request on the diagnostic line, by any change of the active-low enable input, or by undervoltage lockout.

Top module: `led_openstring_guard`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `kill_all` and `diag` are 0, and no latch, channel mask or arming survives.
- R2: An open-load flag is accepted only after it has been high on `FILT_LEN` rising edges with `drive_on` high. A low flag during a driven cycle restarts the count, and cycles with `drive_on` low neither add to the count nor clear it.
- R3: With `latchoff_n` at 0, an accepted open string on any channel sets a latch. From the same clock edge, `kill_all` and `diag` are 1, and both stay 1 after the flag and the drive go away, until a release event occurs.
- R4: With `latchoff_n` at 1, an open string never raises `kill_all`. `diag` still reports it.
- R5: A cycle with `diag_force_low` high, or with `enable_n` different from its value one cycle earlier, clears the latch and all filter counts. `kill_all` falls at that edge unless a bias fault holds it.
- R6: `uvlo` high clears the latch, the channel mask and the arming. The block re-arms on the first following cycle in which `supply_ok` is 1.
- R7: Open-load counting and reporting are suspended in every cycle with `supply_ok` at 0.
- R8: A bit of `chan_gnd` that is 1 in the arming cycle masks that channel's open-load flag until the next reset or undervoltage lockout.
- R9: Without a latch, an accepted open string drives `diag` to 1 only on edges where `drive_on` is 1. In dimmed operation `diag` therefore tracks the drive on-time, and in full-on operation it is steady.
- R10: `overtemp` and `seqout_open` raise both `kill_all` and `diag`. `setback` and `ilim` raise only `diag`. Each fault takes effect one clock edge after it is applied and drops one edge after it is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above the open-load detection threshold |
| uvlo | input | 1 | Undervoltage lockout active |
| chan_gnd | input | NCH | Per-channel "output strapped to ground" indication |
| open_flag | input | NCH | Per-channel open-load comparator result |
| drive_on | input | 1 | Channels currently driven (PWM on-phase or full on) |
| latchoff_n | input | 1 | 0 selects latch-all-off on an open string |
| diag_force_low | input | 1 | Diagnostic line pulled below its reset level |
| enable_n | input | 1 | Active-low global enable; any change releases a latch |
| overtemp | input | 1 | Thermal shutdown |
| setback | input | 1 | Overvoltage current set-back active |
| ilim | input | 1 | Stop-resistor current limit active |
| seqout_open | input | 1 | Sequence output found open |
| kill_all | output | 1 | Force every channel off |
| diag | output | 1 | Fault status, high on any fault |

## Verification
The assertions assume that the undervoltage flag and the release inputs are synchronous to `clk` and are already free of metastability. They also assume that `enable_n` holds a defined value during reset, so that its first post-reset sample does not read as a toggle. The stimulus changes inputs only one time unit after a rising edge and holds `enable_n` steady across reset. It pulses `uvlo` and `diag_force_low` for whole cycles only, which keeps every edge-relative property well defined.

// File: rtl/ols_pkg.sv
package ols_pkg;
  typedef struct packed {
    logic overtemp;
    logic setback;
    logic ilim;
    logic seqout_open;
  } bias_faults_t;

  function automatic logic faults_kill(input bias_faults_t f);
    return f.overtemp | f.seqout_open;
  endfunction

  function automatic logic faults_report(input bias_faults_t f);
    return f.overtemp | f.setback | f.ilim | f.seqout_open;
  endfunction
endpackage

// File: rtl/ols_chan_filter.sv
module ols_chan_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic clr,
  input  logic drive_on,
  input  logic open_flag,
  output logic accepted
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
    end else if (drive_on) begin
      if (!open_flag)
        cnt_q <= '0;
      else if (cnt_q != LIMIT)
        cnt_q <= cnt_q + CW'(1);
    end
  end

  assign accepted = (cnt_q == LIMIT);
endmodule

// File: rtl/ols_unused_mask.sv
module ols_unused_mask #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           uvlo,
  input  logic           supply_ok,
  input  logic [NCH-1:0] chan_gnd,
  output logic           armed_q,
  output logic [NCH-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst || uvlo) begin
      armed_q <= 1'b0;
      mask_q  <= '0;
    end else if (!armed_q && supply_ok) begin
      armed_q <= 1'b1;
      mask_q  <= chan_gnd;
    end
  end
endmodule

// File: rtl/ols_latch.sv
module ols_latch (
  input  logic clk,
  input  logic rst,
  input  logic uvlo,
  input  logic diag_force_low,
  input  logic enable_n,
  input  logic latchoff_n,
  input  logic any_open,
  output logic release_now,
  output logic latch_nxt,
  output logic latched_q
);
  logic en_prev_q;

  assign release_now = diag_force_low | (enable_n ^ en_prev_q);

  always_comb begin
    if (rst || uvlo || release_now)
      latch_nxt = 1'b0;
    else
      latch_nxt = latched_q | (~latchoff_n & any_open);
  end

  always_ff @(posedge clk) begin
    en_prev_q <= enable_n;
    latched_q <= latch_nxt;
  end
endmodule

// File: rtl/led_openstring_guard.sv
module led_openstring_guard #(
  parameter int NCH      = 8,
  parameter int FILT_LEN = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           supply_ok,
  input  logic           uvlo,
  input  logic [NCH-1:0] chan_gnd,
  input  logic [NCH-1:0] open_flag,
  input  logic           drive_on,
  input  logic           latchoff_n,
  input  logic           diag_force_low,
  input  logic           enable_n,
  input  logic           overtemp,
  input  logic           setback,
  input  logic           ilim,
  input  logic           seqout_open,
  output logic           kill_all,
  output logic           diag
);
  import ols_pkg::*;

  logic           armed_q;
  logic [NCH-1:0] mask_q;
  logic [NCH-1:0] acc;
  logic [NCH-1:0] acc_live;
  logic           release_now;
  logic           latch_nxt;
  logic           latched_q;
  logic           detect_en;
  logic           any_open;
  bias_faults_t   faults;

  assign faults    = '{overtemp: overtemp, setback: setback,
                       ilim: ilim, seqout_open: seqout_open};
  assign detect_en = supply_ok & armed_q;

  ols_unused_mask #(.NCH(NCH)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .uvlo      (uvlo),
    .supply_ok (supply_ok),
    .chan_gnd  (chan_gnd),
    .armed_q   (armed_q),
    .mask_q    (mask_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic clr_ch;
    assign clr_ch = rst | uvlo | release_now | ~detect_en | mask_q[ch];

    ols_chan_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk       (clk),
      .clr       (clr_ch),
      .drive_on  (drive_on),
      .open_flag (open_flag[ch]),
      .accepted  (acc[ch])
    );
  end

  assign acc_live = acc & {NCH{supply_ok & ~uvlo & ~release_now}};
  assign any_open = |acc_live;

  ols_latch u_latch (
    .clk            (clk),
    .rst            (rst),
    .uvlo           (uvlo),
    .diag_force_low (diag_force_low),
    .enable_n       (enable_n),
    .latchoff_n     (latchoff_n),
    .any_open       (any_open),
    .release_now    (release_now),
    .latch_nxt      (latch_nxt),
    .latched_q      (latched_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kill_all <= 1'b0;
      diag     <= 1'b0;
    end else begin
      kill_all <= latch_nxt | faults_kill(faults);
      diag     <= latch_nxt | (any_open & drive_on) | faults_report(faults);
    end
  end
endmodule

// File: rtl/ols_checker.sv
module ols_checker #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           uvlo,
  input logic           diag_force_low,
  input logic           enable_n,
  input logic           latchoff_n,
  input logic           overtemp,
  input logic           seqout_open,
  input logic           kill_all,
  input logic           diag,
  input logic           latched_q,
  input logic           armed_q,
  input logic [NCH-1:0] mask_q
);
  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latched_q && !uvlo && !diag_force_low && $stable(enable_n)) |=> latched_q);

  // R3
  latch_kills_chk: assert property (@(posedge clk) disable iff (rst)
    latched_q |-> (kill_all && diag));

  // R4
  no_latch_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!latched_q && latchoff_n) |=> !latched_q);

  // R5
  force_low_release_chk: assert property (@(posedge clk) disable iff (rst)
    diag_force_low |=> !latched_q);

  // R6
  uvlo_clear_chk: assert property (@(posedge clk) disable iff (rst)
    uvlo |=> (!latched_q && !armed_q && mask_q == '0));

  // R8
  mask_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !uvlo) |=> $stable(mask_q));

  // R10
  fault_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (overtemp || seqout_open) |=> (kill_all && diag));
endmodule

bind led_openstring_guard ols_checker #(.NCH(NCH)) u_ols_chk (
  .clk            (clk),
  .rst            (rst),
  .uvlo           (uvlo),
  .diag_force_low (diag_force_low),
  .enable_n       (enable_n),
  .latchoff_n     (latchoff_n),
  .overtemp       (overtemp),
  .seqout_open    (seqout_open),
  .kill_all       (kill_all),
  .diag           (diag),
  .latched_q      (latched_q),
  .armed_q        (armed_q),
  .mask_q         (mask_q)
);

// File: tb/test_led_openstring_guard.sv
module test_led_openstring_guard;
  localparam int NCH = 8;
  localparam int L   = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst = 1'b1, supply_ok = 1'b0, uvlo = 1'b0, drive_on = 1'b0;
  logic [NCH-1:0] chan_gnd = '0, open_flag = '0;
  logic           latchoff_n = 1'b1, diag_force_low = 1'b0, enable_n = 1'b0;
  logic           overtemp = 1'b0, setback = 1'b0, ilim = 1'b0, seqout_open = 1'b0;
  logic           kill_all, diag;

  led_openstring_guard #(.NCH(NCH), .FILT_LEN(L)) i_led_openstring_guard (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .uvlo(uvlo),
    .chan_gnd(chan_gnd), .open_flag(open_flag), .drive_on(drive_on),
    .latchoff_n(latchoff_n), .diag_force_low(diag_force_low),
    .enable_n(enable_n), .overtemp(overtemp), .setback(setback),
    .ilim(ilim), .seqout_open(seqout_open), .kill_all(kill_all), .diag(diag)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int  m_cnt[NCH];
  bit  m_lat, m_armed, m_en, m_kill, m_diag;
  bit  [NCH-1:0] m_mask;

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit rel, any, nlat;
    rel = diag_force_low || (enable_n != m_en);
    any = 0;
    for (int i = 0; i < NCH; i++)
      if (m_cnt[i] == L && supply_ok && !uvlo && !rel) any = 1;
    if (rst || uvlo || rel) nlat = 0;
    else nlat = m_lat || (!latchoff_n && any);
    m_kill = rst ? 0 : (nlat || overtemp || seqout_open);
    m_diag = rst ? 0 : (nlat || (any && drive_on) || overtemp || setback || ilim || seqout_open);
    for (int i = 0; i < NCH; i++) begin
      if (rst || uvlo || rel || !(supply_ok && m_armed) || m_mask[i]) m_cnt[i] = 0;
      else if (drive_on) m_cnt[i] = open_flag[i] ? ((m_cnt[i] < L) ? m_cnt[i] + 1 : L) : 0;
    end
    if (rst || uvlo) begin m_armed = 0; m_mask = '0; end
    else if (!m_armed && supply_ok) begin m_armed = 1; m_mask = chan_gnd; end
    m_lat = nlat;
    m_en  = enable_n;
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_step();
      #1;
      chk(cur_req, kill_all, m_kill, "model kill_all");
      chk(cur_req, diag, m_diag, "model diag");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
    // R1 reset state
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1", kill_all, 1'b0, "kill after reset");
    chk("R1", diag, 1'b0, "diag after reset");

    // R8 arming with channel 6 grounded
    cur_req = "R8";
    chan_gnd = 8'h40; supply_ok = 1'b1;
    tick(1);
    chan_gnd = '0;

    // R4 report only, R9 PWM gating
    cur_req = "R4";
    latchoff_n = 1'b1; drive_on = 1'b1; open_flag = 8'h02;
    tick(6);
    chk("R4", kill_all, 1'b0, "no kill without latch select");
    chk("R4", diag, 1'b1, "open reported");
    cur_req = "R9";
    drive_on = 1'b0;
    tick(1);
    chk("R9", diag, 1'b0, "diag low in off phase");
    drive_on = 1'b1;
    tick(1);
    chk("R9", diag, 1'b1, "diag back in on phase");
    open_flag = '0;
    tick(2);

    // R2 glitch filter
    cur_req = "R2";
    for (int r = 0; r < 3; r++) begin
      open_flag = 8'h01; tick(L - 1);
      open_flag = 8'h00; tick(1);
    end
    chk("R2", diag, 1'b0, "short pulses rejected");
    open_flag = 8'h01; tick(2);
    drive_on = 1'b0; tick(3);
    drive_on = 1'b1; tick(L);
    chk("R2", diag, 1'b1, "count held across off phase");
    open_flag = '0; tick(2);

    // R3 latch-off
    cur_req = "R3";
    latchoff_n = 1'b0; open_flag = 8'h08;
    tick(6);
    chk("R3", kill_all, 1'b1, "latched kill");
    open_flag = '0; drive_on = 1'b0;
    tick(3);
    chk("R3", kill_all, 1'b1, "kill held");
    chk("R3", diag, 1'b1, "diag held");

    // R5 releases
    cur_req = "R5";
    diag_force_low = 1'b1; tick(1); diag_force_low = 1'b0;
    chk("R5", kill_all, 1'b0, "force-low release");
    drive_on = 1'b1; open_flag = 8'h08; tick(6);
    open_flag = '0;
    chk("R5", kill_all, 1'b1, "relatched");
    enable_n = 1'b1; tick(1);
    chk("R5", kill_all, 1'b0, "enable toggle release");
    enable_n = 1'b0; tick(2);

    // R8 masked channel ignored
    cur_req = "R8";
    open_flag = 8'h40; tick(7);
    chk("R8", kill_all, 1'b0, "masked channel no kill");
    chk("R8", diag, 1'b0, "masked channel no report");
    open_flag = '0;

    // R7 supply gating
    cur_req = "R7";
    supply_ok = 1'b0; open_flag = 8'h04; tick(7);
    chk("R7", kill_all, 1'b0, "no detect below threshold");
    chk("R7", diag, 1'b0, "no report below threshold");
    open_flag = '0; supply_ok = 1'b1; tick(1);

    // R6 undervoltage clears latch and mask
    cur_req = "R6";
    open_flag = 8'h04; tick(6);
    chk("R6", kill_all, 1'b1, "latched before uvlo");
    open_flag = '0; uvlo = 1'b1; tick(1); uvlo = 1'b0;
    chk("R6", kill_all, 1'b0, "uvlo release");
    open_flag = 8'h40; tick(8);
    chk("R6", kill_all, 1'b1, "mask cleared by uvlo");
    open_flag = '0;
    diag_force_low = 1'b1; tick(1); diag_force_low = 1'b0;

    // R10 bias faults
    cur_req = "R10";
    drive_on = 1'b0;
    overtemp = 1'b1; tick(1);
    chk("R10", kill_all, 1'b1, "overtemp kill");
    chk("R10", diag, 1'b1, "overtemp diag");
    overtemp = 1'b0; tick(1);
    chk("R10", kill_all, 1'b0, "overtemp removed");
    setback = 1'b1; tick(1);
    chk("R10", kill_all, 1'b0, "setback no kill");
    chk("R10", diag, 1'b1, "setback diag");
    setback = 1'b0; ilim = 1'b1; tick(1);
    chk("R10", diag, 1'b1, "ilim diag");
    ilim = 1'b0; seqout_open = 1'b1; tick(1);
    chk("R10", kill_all, 1'b1, "seqout kill");
    seqout_open = 1'b0; tick(2);
    chk("R10", diag, 1'b0, "faults cleared");

    // R1 mid-run reset
    cur_req = "R1";
    latchoff_n = 1'b0; drive_on = 1'b1; open_flag = 8'h10; tick(6);
    rst = 1'b1; open_flag = '0; tick(2);
    chk("R1", kill_all, 1'b0, "kill in reset");
    rst = 1'b0; tick(1);
    chk("R1", diag, 1'b0, "diag after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule